// File: doc/BRIEF.md
# Priority Interrupt Controller with Mask Levels

This block picks one interrupt to present to a small CPU from three kinds of request input. The first is a non-maskable request. The second is a bank of external request lines. The third is a bank of on-chip peripheral request lines. Each maskable line has its own enable input. Each line belongs to a priority group, and each group has a 3-bit priority that software sets through a narrow write port. The CPU's masking state reaches the block as two inputs: a global mask bit and a 3-bit mask level. A 2-bit control-mode input selects which of the two applies.

When the block is idle it arbitrates every clock. It registers the winner one clock later and presents a request flag, the vector number, the 16-bit vector address and the winner's priority level. These outputs hold until the CPU pulses the acknowledge input. After the acknowledge the block spends one idle clock and then arbitrates again. The standby input blocks all requests and drops any request being presented.

Top module: `pic_top`

## Requirements
- R1: While reset is low and after reset is released, int_req is 0, int_vec, int_addr and int_lvl are 0, and every group priority is 7.
- R2: Outside standby, an asserted nmi_req wins over every maskable source whatever the masks or mode are, and is presented with vector 7 and level 7.
- R3: When standby is high at a clock edge, no request is taken at that edge and any request being presented is dropped, so int_req is 0 after that edge.
- R4: A maskable line whose enable bit is 0 never wins arbitration, whatever its request level is.
- R5: When ctl_mode bit 1 is 0 (modes 00 and 01), gmask = 1 blocks every maskable source, and gmask = 0 admits every enabled one.
- R6: When ctl_mode bit 1 is 1 (modes 10 and 11), a maskable source is admitted only if its group priority is strictly greater than lvl_mask.
- R7: Among admitted sources the one with the highest group priority wins. On a tie the lower vector number wins.
- R8: External line i has vector 16+i and forms group i. Peripheral line j has vector 104+j and belongs to group N_IRQ + j/3. Vectors 110 and 111 are never presented.
- R9: int_addr equals the presented vector number multiplied by 4, as a 16-bit value.
- R10: A request appears on the outputs one clock after arbitration. The vector and level hold unchanged until ack is sampled high. The outputs then return to 0 for at least one clock before the next winner appears.
- R11: A priority write (pw_en, with group index pw_grp) takes part in arbitration from the next clock onward. A write whose group index is N_GRP or higher changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Hardware standby; blocks all requests |
| nmi_req | input | 1 | Non-maskable request |
| irq_req | input | N_IRQ | External request lines |
| irq_en | input | N_IRQ | Enable per external line |
| per_req | input | N_PER | Peripheral request lines |
| per_en | input | N_PER | Enable per peripheral line |
| ctl_mode | input | 2 | Masking mode; bit 1 selects level masking |
| gmask | input | 1 | Global mask bit |
| lvl_mask | input | 3 | Current mask level |
| pw_en | input | 1 | Priority write strobe |
| pw_grp | input | GRP_W | Group index for a write |
| pw_prio | input | 3 | Priority value to write |
| ack | input | 1 | Acknowledge of the presented request |
| int_req | output | 1 | Request presented to the CPU |
| int_vec | output | 8 | Presented vector number |
| int_addr | output | 16 | Presented vector address |
| int_lvl | output | 3 | Priority level of the presented request |

## Verification
A wrong held state would show up as int_vec or int_lvl changing while ack is low, or as int_req staying high after an acknowledge or after standby. Any of these is visible at the ports on the next clock. A corrupted group priority would not show until the corrupted group competes with another admitted source or meets the mask level. The reference model therefore drives mixed priorities, ties, random writes and random mask levels, so that such a fault changes a winner within a few acknowledge cycles. Every clock compares all four outputs against the model, so a divergence is reported in the cycle it first appears.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int PRIO_W = 3;
    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [7:0]        vec_t;

    localparam vec_t  NMI_VEC      = 8'd7;
    localparam int    IRQ_VEC_BASE = 16;
    localparam int    PER_VEC_BASE = 104;
    localparam vec_t  RSV_VEC_A    = 8'd110;
    localparam vec_t  RSV_VEC_B    = 8'd111;
    localparam prio_t NMI_LVL      = 3'd7;
    localparam prio_t PRIO_RST     = 3'd7;

    typedef struct packed {
        logic  req;
        vec_t  vec;
        prio_t lvl;
    } pend_t;

    function automatic vec_t src_vector(input int idx, input int n_irq);
        if (idx < n_irq) return vec_t'(IRQ_VEC_BASE + idx);
        return vec_t'(PER_VEC_BASE + idx - n_irq);
    endfunction

    function automatic int src_group(input int idx, input int n_irq, input int per_grp);
        if (idx < n_irq) return idx;
        return n_irq + (idx - n_irq) / per_grp;
    endfunction
endpackage

// File: rtl/pic_prio_regs.sv
module pic_prio_regs
    import pic_pkg::*;
#(
    parameter int N_GRP = 10,
    parameter int GRP_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [GRP_W-1:0]   wr_grp,
    input  prio_t              wr_data,
    output logic [N_GRP*PRIO_W-1:0] prio_flat
);
    prio_t prio_d [N_GRP];
    prio_t prio_q [N_GRP];

    always_comb begin
        for (int g = 0; g < N_GRP; g++) begin
            prio_d[g] = prio_q[g];
            if (wr_en && (wr_grp == GRP_W'(g))) prio_d[g] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < N_GRP; g++) prio_q[g] <= PRIO_RST;
        end else begin
            for (int g = 0; g < N_GRP; g++) prio_q[g] <= prio_d[g];
        end
    end

    for (genvar g = 0; g < N_GRP; g++) begin : g_flat
        assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q[g];
    end
endmodule

// File: rtl/pic_mask_filter.sv
module pic_mask_filter
    import pic_pkg::*;
#(
    parameter int N_SRC   = 14,
    parameter int N_IRQ   = 8,
    parameter int PER_GRP = 3,
    parameter int N_GRP   = 10
) (
    input  logic [N_SRC-1:0]        src_req,
    input  logic [N_SRC-1:0]        src_en,
    input  logic [N_GRP*PRIO_W-1:0] prio_flat,
    input  logic                    lvl_mode,
    input  logic                    gmask,
    input  prio_t                   lvl_mask,
    output logic [N_SRC-1:0]        elig,
    output logic [N_SRC*PRIO_W-1:0] src_prio
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        localparam int GRP = src_group(i, N_IRQ, PER_GRP);
        prio_t p;
        logic  admit;
        assign p     = prio_flat[GRP*PRIO_W +: PRIO_W];
        assign admit = lvl_mode ? (p > lvl_mask) : !gmask;
        assign elig[i] = src_req[i] && src_en[i] && admit;
        assign src_prio[i*PRIO_W +: PRIO_W] = p;
    end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
    import pic_pkg::*;
#(
    parameter int N_SRC = 14,
    parameter int N_IRQ = 8
) (
    input  logic                    nmi_ok,
    input  logic [N_SRC-1:0]        elig,
    input  logic [N_SRC*PRIO_W-1:0] src_prio,
    output logic                    win_valid,
    output vec_t                    win_vec,
    output prio_t                   win_lvl
);
    always_comb begin
        win_valid = 1'b0;
        win_vec   = '0;
        win_lvl   = '0;
        // ascending vector order; strict compare keeps the lower vector on ties
        for (int i = 0; i < N_SRC; i++) begin
            if (elig[i] && (!win_valid || (src_prio[i*PRIO_W +: PRIO_W] > win_lvl))) begin
                win_valid = 1'b1;
                win_lvl   = src_prio[i*PRIO_W +: PRIO_W];
                win_vec   = src_vector(i, N_IRQ);
            end
        end
        if (nmi_ok) begin
            win_valid = 1'b1;
            win_vec   = NMI_VEC;
            win_lvl   = NMI_LVL;
        end
    end
endmodule

// File: rtl/pic_top.sv
module pic_top
    import pic_pkg::*;
#(
    parameter int N_IRQ   = 8,
    parameter int N_PER   = 6,
    parameter int PER_GRP = 3,
    parameter int N_GRP   = N_IRQ + (N_PER + PER_GRP - 1) / PER_GRP,
    parameter int GRP_W   = $clog2(N_GRP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby,
    input  logic             nmi_req,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic [N_PER-1:0] per_req,
    input  logic [N_PER-1:0] per_en,
    input  logic [1:0]       ctl_mode,
    input  logic             gmask,
    input  logic [2:0]       lvl_mask,
    input  logic             pw_en,
    input  logic [GRP_W-1:0] pw_grp,
    input  logic [2:0]       pw_prio,
    input  logic             ack,
    output logic             int_req,
    output logic [7:0]       int_vec,
    output logic [15:0]      int_addr,
    output logic [2:0]       int_lvl
);
    localparam int N_SRC = N_IRQ + N_PER;

    logic [N_GRP*PRIO_W-1:0] prio_flat;
    logic [N_SRC-1:0]        elig;
    logic [N_SRC*PRIO_W-1:0] src_prio;
    logic                    win_valid;
    vec_t                    win_vec;
    prio_t                   win_lvl;
    pend_t                   st_d, st_q;

    pic_prio_regs #(.N_GRP(N_GRP), .GRP_W(GRP_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(pw_en), .wr_grp(pw_grp),
        .wr_data(pw_prio), .prio_flat(prio_flat)
    );

    pic_mask_filter #(.N_SRC(N_SRC), .N_IRQ(N_IRQ), .PER_GRP(PER_GRP), .N_GRP(N_GRP)) u_filt (
        .src_req({per_req, irq_req}), .src_en({per_en, irq_en}), .prio_flat(prio_flat),
        .lvl_mode(ctl_mode[1]), .gmask(gmask), .lvl_mask(lvl_mask),
        .elig(elig), .src_prio(src_prio)
    );

    pic_arbiter #(.N_SRC(N_SRC), .N_IRQ(N_IRQ)) u_arb (
        .nmi_ok(nmi_req && !standby), .elig(elig), .src_prio(src_prio),
        .win_valid(win_valid), .win_vec(win_vec), .win_lvl(win_lvl)
    );

    always_comb begin
        st_d = st_q;
        if (standby) begin
            st_d = '0;
        end else if (st_q.req) begin
            if (ack) st_d = '0;
        end else if (win_valid) begin
            st_d.req = 1'b1;
            st_d.vec = win_vec;
            st_d.lvl = win_lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign int_req  = st_q.req;
    assign int_vec  = st_q.vec;
    assign int_lvl  = st_q.lvl;
    assign int_addr = {6'd0, st_q.vec, 2'b00};

    // R10: presented vector frozen until acknowledged
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        int_req && !ack && !standby |=> int_req && $stable(int_vec) && $stable(int_lvl));

    // R10: acknowledge releases the request
    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        int_req && ack |=> !int_req);

    // R8: reserved vectors never appear
    p_rsv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> (int_vec != RSV_VEC_A) && (int_vec != RSV_VEC_B));

    // R2: non-maskable request taken whenever idle outside standby
    p_nmi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !int_req && nmi_req && !standby |=> int_req && int_vec == NMI_VEC && int_lvl == NMI_LVL);

    // R3: standby drops the request
    p_standby_r3: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> !int_req);

    // R5: global mask blocks every maskable source
    p_gmask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !int_req && !ctl_mode[1] && gmask && !nmi_req |=> !int_req);

    // R6: an admitted maskable source lies strictly above the mask level
    p_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !int_req && !standby && ctl_mode[1] && !nmi_req && win_valid |=> int_lvl > $past(lvl_mask));
endmodule

// File: tb/tb_pic_top.sv
`timescale 1ns/1ps
module tb_pic_top;
    localparam int NI = 8;
    localparam int NP = 6;
    localparam int NG = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic standby = 0, nmi = 0, gmask = 0, pw_en = 0, ack = 0;
    logic [NI-1:0] irq = '0, irq_en = '0;
    logic [NP-1:0] per = '0, per_en = '0;
    logic [1:0] mode = 2'b00;
    logic [2:0] lvl = 3'd0, pw_prio = 3'd0;
    logic [3:0] pw_grp = 4'd0;
    logic int_req;
    logic [7:0] int_vec;
    logic [15:0] int_addr;
    logic [2:0] int_lvl;

    always #2.5 clk = ~clk;

    pic_top dut (
        .clk(clk), .rst_n(rst_n), .standby(standby), .nmi_req(nmi),
        .irq_req(irq), .irq_en(irq_en), .per_req(per), .per_en(per_en),
        .ctl_mode(mode), .gmask(gmask), .lvl_mask(lvl), .pw_en(pw_en),
        .pw_grp(pw_grp), .pw_prio(pw_prio), .ack(ack),
        .int_req(int_req), .int_vec(int_vec), .int_addr(int_addr), .int_lvl(int_lvl)
    );

    int n_chk = 0, n_bad = 0;
    int m_prio [NG];
    bit m_req = 0;
    int m_vec = 0, m_lvl = 0;
    string tag = "R1";
    bit auto_ack = 1;
    bit done = 0;

    function automatic bit admitted(int p);
        return mode[1] ? (p > int'(lvl)) : !gmask;
    endfunction

    function automatic void model_step();
        int best, bv;
        if (!rst_n) begin
            m_req = 0; m_vec = 0; m_lvl = 0;
            foreach (m_prio[g]) m_prio[g] = 7;
            return;
        end
        if (standby) begin
            m_req = 0; m_vec = 0; m_lvl = 0;
        end else if (m_req) begin
            if (ack) begin m_req = 0; m_vec = 0; m_lvl = 0; end
        end else if (nmi) begin
            m_req = 1; m_vec = 7; m_lvl = 7;
        end else begin
            best = -1; bv = 0;
            for (int i = 0; i < NI; i++)
                if (irq[i] && irq_en[i] && admitted(m_prio[i]) && m_prio[i] > best) begin
                    best = m_prio[i]; bv = 16 + i;
                end
            for (int j = 0; j < NP; j++)
                if (per[j] && per_en[j] && admitted(m_prio[NI + j/3]) && m_prio[NI + j/3] > best) begin
                    best = m_prio[NI + j/3]; bv = 104 + j;
                end
            if (best >= 0) begin m_req = 1; m_vec = bv; m_lvl = best; end
        end
        if (pw_en && int'(pw_grp) < NG) m_prio[pw_grp] = int'(pw_prio);
    endfunction

    task automatic tick();
        @(negedge clk);
        model_step();
        n_chk++;
        if (int_req !== m_req || int_vec !== 8'(m_vec) || int_addr !== 16'(m_vec*4) || int_lvl !== 3'(m_lvl)) begin
            n_bad++;
            $display("FAIL %s: req/vec/addr/lvl = %0d/%0d/%0h/%0d expected %0d/%0d/%0h/%0d",
                     tag, int_req, int_vec, int_addr, int_lvl, m_req, m_vec, m_vec*4, m_lvl);
        end
        if (auto_ack) ack = m_req && ($urandom % 4 == 0);
    endtask

    task automatic drive_rand(int nmi_pct, int stby_pct, int wr_pct, int prio_max);
        irq = NI'($urandom); irq_en = NI'($urandom);
        per = NP'($urandom); per_en = NP'($urandom);
        gmask = 1'($urandom); lvl = 3'($urandom);
        nmi = ($urandom % 100) < nmi_pct;
        standby = ($urandom % 100) < stby_pct;
        pw_en = ($urandom % 100) < wr_pct;
        pw_grp = 4'($urandom);
        pw_prio = 3'($urandom % prio_max);
    endtask

    task automatic run(string t, int n, logic [1:0] md, int nmi_pct, int stby_pct, int wr_pct, int pmax);
        tag = t;
        for (int k = 0; k < n; k++) begin
            drive_rand(nmi_pct, stby_pct, wr_pct, pmax);
            mode = md;
            tick();
        end
    endtask

    initial begin
        void'($urandom(7));
        // R1: reset state and reset priority 7 (all-enabled sources see level 7)
        tag = "R1";
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        mode = 2'b10; lvl = 3'd6; irq = 8'h80; irq_en = 8'h80;
        tick(); tick();
        irq = '0; irq_en = '0;
        repeat (4) tick();
        // R11: random priority writes, including out-of-range groups
        run("R11", 300, 2'b10, 0, 0, 40, 8);
        // R4: enables
        run("R4", 200, 2'b00, 0, 0, 5, 8);
        // R5: global mask mode, both codes
        run("R5", 150, 2'b00, 0, 0, 5, 8);
        run("R5", 150, 2'b01, 0, 0, 5, 8);
        // R6: level mask mode, both codes
        run("R6", 150, 2'b10, 0, 0, 5, 8);
        run("R6", 150, 2'b11, 0, 0, 5, 8);
        // R7: many ties from a narrow priority range
        run("R7", 300, 2'b10, 0, 0, 30, 3);
        // R2: non-maskable against every mode
        run("R2", 200, 2'b00, 30, 0, 5, 8);
        run("R2", 200, 2'b11, 30, 0, 5, 8);
        // R3: standby pulses
        run("R3", 250, 2'b10, 20, 25, 5, 8);
        // R8 R9: each peripheral line alone, priority 7, held until acknowledged
        tag = "R8 R9";
        auto_ack = 0; ack = 0; nmi = 0; standby = 0; pw_en = 0;
        mode = 2'b00; gmask = 0; irq = '0; irq_en = '0; per_en = '1;
        for (int g = NI; g < NG; g++) begin
            pw_en = 1; pw_grp = 4'(g); pw_prio = 3'd7; tick();
        end
        pw_en = 0;
        for (int j = 0; j < NP; j++) begin
            per = NP'(1 << j);
            repeat (3) tick();
            ack = 1; tick(); ack = 0;
            per = '0; tick();
        end
        // R10: long holds without acknowledge, then random acknowledges
        tag = "R10";
        drive_rand(0, 0, 0, 8); mode = 2'b00; gmask = 0; irq = '1; irq_en = '1;
        repeat (20) tick();
        auto_ack = 1;
        run("R10", 300, 2'b10, 5, 0, 10, 8);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule